// File: doc/BRIEF.md
# System Exception Pend and Status Register

This block keeps the pending, active and enable state of eight fixed system exceptions: the non-maskable interrupt, the pendable service request, the periodic tick, the memory fault, the bus fault, the usage fault, the supervisor call and the debug monitor. Software sees two 32-bit words through a word-wide register port. The control word sets and clears pending bits and reads back the number of the running vector and of the highest pending vector. The handler word reports per-exception active and pending flags and holds three fault enables.

Hardware requests pend an exception. An acknowledge moves it from pending to active, and a completion retires it. Every exception is a small four-state machine: QUIET (neither flag), WAITING (pending), SERVING (active) and SERV_WAIT (active and pending again). A set request moves QUIET to WAITING, SERVING to SERV_WAIT and keeps WAITING and SERV_WAIT. An acknowledge moves WAITING to SERVING, or to SERV_WAIT when a set arrives in the same cycle. A clear without a set moves WAITING to QUIET and SERV_WAIT to SERVING. A completion moves SERVING to QUIET, or to WAITING under a set. Priority arbitration happens elsewhere. The running vector and the highest pending vector arrive as inputs in internal numbering, and the block converts them to architectural numbers.

Top module: `sxs_status_regs`

## Requirements
- R1: A control-word write with bit 31 set pends the non-maskable interrupt (index 0). No software write clears it.
- R2: In the control word, bit 28 pends the pendable service request (index 1) and bit 27 clears it. When both bits are 1, the set takes effect.
- R3: In the control word, bit 26 pends the tick (index 2) and bit 25 clears it. When both bits are 1, the set takes effect.
- R4: The control word reads back the pending state of index 0 at bit 31, of index 1 at bit 28 and of index 2 at bit 26.
- R5: Bits [8:0] of the control word carry the running vector. They read 0 when the input equals 1023, the input minus 16 when the input is 32 or more, and the input unchanged otherwise. The input range is 0 to 527, plus 1023.
- R6: Bits [20:12] of the control word carry the highest pending vector under the same mapping as R5, and they read 0 for the idle code 1023.
- R7: The handler word reports active flags at these bits: memory fault (index 3) at bit 0, bus fault (index 4) at bit 1, usage fault (index 5) at bit 3, supervisor call (index 6) at bit 7, debug (index 7) at bit 8, pendable service at bit 10 and tick at bit 11.
- R8: The handler word reports pending flags at these bits: usage fault at bit 12, memory fault at bit 13, bus fault at bit 14 and supervisor call at bit 15.
- R9: A handler-word write loads the memory, bus and usage fault enables from bits 16, 17 and 18, and they read back there. The write leaves every active and pending flag unchanged.
- R10: An acknowledge for an index whose exception is pending makes it active and not pending after one clock. It stays pending if a set for the same index arrives in the same cycle. An acknowledge for an index that is not pending has no effect.
- R11: A completion clears the active flag of its index after one clock. An acknowledge of a pending exception with the same index in the same cycle wins, and the flag stays active.
- R12: A hardware set request and a software clear for the same exception in the same cycle leave it pending.
- R13: After reset, every pending, active and enable flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | Word select: 0 for the control word, 1 for the handler word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| hw_set | input | 8 | Per-exception hardware pend requests, by index |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 3 | Index being acknowledged |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 3 | Index being completed |
| run_vec | input | 10 | Running vector in internal numbering, 1023 when idle |
| top_pend_vec | input | 10 | Highest pending vector in internal numbering, 1023 when idle |

## Verification
Several of the block's functions can land in the same cycle, and each pair needs its own stimulus. A hardware pend can meet a software clear of the same tick bit. An acknowledge can meet a new set, or a completion, for the same index. The bench drives each pair within a single clock and then reads both words: a set must leave the exception pending, and an acknowledge must leave it active. The same pairs are checked as clocked properties on every cycle of the run.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
    localparam int NUM_EXC = 8;
    localparam int IDX_W   = $clog2(NUM_EXC);

    localparam int EX_NMI   = 0;
    localparam int EX_PSV   = 1;
    localparam int EX_TICK  = 2;
    localparam int EX_MEM   = 3;
    localparam int EX_BUS   = 4;
    localparam int EX_USAGE = 5;
    localparam int EX_SVC   = 6;
    localparam int EX_DBG   = 7;

    // control word strobes
    localparam int CW_NMI_SET  = 31;
    localparam int CW_PSV_SET  = 28;
    localparam int CW_PSV_CLR  = 27;
    localparam int CW_TICK_SET = 26;
    localparam int CW_TICK_CLR = 25;

    // handler word fields
    localparam int HW_ACT_MEM   = 0;
    localparam int HW_ACT_BUS   = 1;
    localparam int HW_ACT_USAGE = 3;
    localparam int HW_ACT_SVC   = 7;
    localparam int HW_ACT_DBG   = 8;
    localparam int HW_ACT_PSV   = 10;
    localparam int HW_ACT_TICK  = 11;
    localparam int HW_PND_USAGE = 12;
    localparam int HW_PND_MEM   = 13;
    localparam int HW_PND_BUS   = 14;
    localparam int HW_PND_SVC   = 15;
    localparam int HW_EN_LSB    = 16;
    localparam int NUM_EN       = 3;

    // {active, pending}
    typedef enum logic [1:0] {
        QUIET     = 2'b00,
        WAITING   = 2'b01,
        SERVING   = 2'b10,
        SERV_WAIT = 2'b11
    } cell_st_e;
endpackage

// File: rtl/sxs_cell.sv
module sxs_cell
    import sxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic take,
    input  logic finish,
    output logic pend,
    output logic act
);
    cell_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            QUIET: begin
                if (set_req) st_d = WAITING;
            end
            WAITING: begin
                if (take)          st_d = set_req ? SERV_WAIT : SERVING;
                else if (set_req)  st_d = WAITING;
                else if (clr_req)  st_d = QUIET;
            end
            SERVING: begin
                if (finish) st_d = set_req ? WAITING : QUIET;
                else        st_d = set_req ? SERV_WAIT : SERVING;
            end
            SERV_WAIT: begin
                st_d = cell_st_e'({take | ~finish, set_req | ~(clr_req | take)});
            end
            default: st_d = QUIET;
        endcase
    end

    always_comb begin
        pend = (st_q == WAITING) || (st_q == SERV_WAIT);
        act  = (st_q == SERVING) || (st_q == SERV_WAIT);
    end
endmodule

// File: rtl/sxs_vec_map.sv
module sxs_vec_map #(
    parameter int VEC_W     = 10,
    parameter int FLD_W     = 9,
    parameter int REBASE_AT = 32,
    parameter int REBASE_BY = 16
) (
    input  logic [VEC_W-1:0] vin,
    output logic [FLD_W-1:0] vout
);
    localparam logic [VEC_W-1:0] IDLE_CODE = {VEC_W{1'b1}};
    localparam logic [VEC_W-1:0] AT_V      = VEC_W'(REBASE_AT);
    localparam logic [VEC_W-1:0] BY_V      = VEC_W'(REBASE_BY);

    logic [VEC_W-1:0] shifted;

    always_comb begin
        if (vin == IDLE_CODE)  shifted = '0;
        else if (vin >= AT_V)  shifted = vin - BY_V;
        else                   shifted = vin;
        vout = shifted[FLD_W-1:0];
    end
endmodule

// File: rtl/sxs_status_regs.sv
module sxs_status_regs
    import sxs_pkg::*;
#(
    parameter int VEC_W     = 10,
    parameter int FLD_W     = 9,
    parameter int PEND_LSB  = 12,
    parameter int REBASE_AT = 32,
    parameter int REBASE_BY = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_sel,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_EXC-1:0]    hw_set,
    input  logic                  ack_valid,
    input  logic [IDX_W-1:0]      ack_id,
    input  logic                  done_valid,
    input  logic [IDX_W-1:0]      done_id,
    input  logic [VEC_W-1:0]      run_vec,
    input  logic [VEC_W-1:0]      top_pend_vec
);
    logic [NUM_EXC-1:0] set_vec, clr_vec, take_vec, fin_vec;
    logic [NUM_EXC-1:0] pend_q, act_q;
    logic [NUM_EXC-1:0] sw_set, sw_clr;
    logic [NUM_EN-1:0]  en_q;
    logic [FLD_W-1:0]   run_fld, pnd_fld;
    logic [31:0]        ctrl_word, hnd_word;
    logic               ctrl_wr, hnd_wr;

    assign ctrl_wr = reg_wr & ~reg_sel;
    assign hnd_wr  = reg_wr &  reg_sel;

    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        sw_set[EX_NMI]  = ctrl_wr & reg_wdata[CW_NMI_SET];
        sw_set[EX_PSV]  = ctrl_wr & reg_wdata[CW_PSV_SET];
        sw_clr[EX_PSV]  = ctrl_wr & reg_wdata[CW_PSV_CLR];
        sw_set[EX_TICK] = ctrl_wr & reg_wdata[CW_TICK_SET];
        sw_clr[EX_TICK] = ctrl_wr & reg_wdata[CW_TICK_CLR];
    end

    assign set_vec = hw_set | sw_set;
    assign clr_vec = sw_clr;

    generate
        for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
            assign take_vec[i] = ack_valid  && (ack_id  == IDX_W'(i));
            assign fin_vec[i]  = done_valid && (done_id == IDX_W'(i));
            sxs_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_req (set_vec[i]),
                .clr_req (clr_vec[i]),
                .take    (take_vec[i]),
                .finish  (fin_vec[i]),
                .pend    (pend_q[i]),
                .act     (act_q[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (hnd_wr) en_q <= reg_wdata[HW_EN_LSB +: NUM_EN];
    end

    sxs_vec_map #(.VEC_W(VEC_W), .FLD_W(FLD_W), .REBASE_AT(REBASE_AT), .REBASE_BY(REBASE_BY))
        u_run_map (.vin(run_vec), .vout(run_fld));
    sxs_vec_map #(.VEC_W(VEC_W), .FLD_W(FLD_W), .REBASE_AT(REBASE_AT), .REBASE_BY(REBASE_BY))
        u_pnd_map (.vin(top_pend_vec), .vout(pnd_fld));

    always_comb begin
        ctrl_word = '0;
        ctrl_word[FLD_W-1:0]             = run_fld;
        ctrl_word[PEND_LSB +: FLD_W]     = pnd_fld;
        ctrl_word[CW_NMI_SET]            = pend_q[EX_NMI];
        ctrl_word[CW_PSV_SET]            = pend_q[EX_PSV];
        ctrl_word[CW_TICK_SET]           = pend_q[EX_TICK];

        hnd_word = '0;
        hnd_word[HW_ACT_MEM]             = act_q[EX_MEM];
        hnd_word[HW_ACT_BUS]             = act_q[EX_BUS];
        hnd_word[HW_ACT_USAGE]           = act_q[EX_USAGE];
        hnd_word[HW_ACT_SVC]             = act_q[EX_SVC];
        hnd_word[HW_ACT_DBG]             = act_q[EX_DBG];
        hnd_word[HW_ACT_PSV]             = act_q[EX_PSV];
        hnd_word[HW_ACT_TICK]            = act_q[EX_TICK];
        hnd_word[HW_PND_USAGE]           = pend_q[EX_USAGE];
        hnd_word[HW_PND_MEM]             = pend_q[EX_MEM];
        hnd_word[HW_PND_BUS]             = pend_q[EX_BUS];
        hnd_word[HW_PND_SVC]             = pend_q[EX_SVC];
        hnd_word[HW_EN_LSB +: NUM_EN]    = en_q;

        reg_rdata = reg_sel ? hnd_word : ctrl_word;
    end
endmodule

// File: rtl/sxs_status_chk.sv
module sxs_status_chk
    import sxs_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                reg_sel,
    input logic [31:0]         reg_wdata,
    input logic [NUM_EXC-1:0]  hw_set,
    input logic                ack_valid,
    input logic [IDX_W-1:0]    ack_id,
    input logic                done_valid,
    input logic [IDX_W-1:0]    done_id,
    input logic [NUM_EXC-1:0]  pend_q,
    input logic [NUM_EXC-1:0]  act_q,
    input logic [NUM_EN-1:0]   en_q
);
    // R1
    nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[CW_NMI_SET]) |=> pend_q[EX_NMI]);

    // R2
    psv_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[CW_PSV_SET]) |=> pend_q[EX_PSV]);

    // R3
    tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[CW_TICK_CLR] && !reg_wdata[CW_TICK_SET]
         && !hw_set[EX_TICK] && !(ack_valid && ack_id == IDX_W'(EX_TICK)))
        |=> !pend_q[EX_TICK]);

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel) |=> $stable(en_q));

    // R10
    ack_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && pend_q[ack_id]) |=> act_q[$past(ack_id)]);

    // R11
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !(ack_valid && ack_id == done_id && pend_q[done_id]))
        |=> !act_q[$past(done_id)]);

    // R12
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));
endmodule

bind sxs_status_regs sxs_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .hw_set     (hw_set),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .done_valid (done_valid),
    .done_id    (done_id),
    .pend_q     (pend_q),
    .act_q      (act_q),
    .en_q       (en_q)
);

// File: tb/sim_sxs_status_regs.sv
`timescale 1ns/100ps
module sim_sxs_status_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  hw_set = '0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_id = '0;
    logic        done_valid = 1'b0;
    logic [2:0]  done_id = '0;
    logic [9:0]  run_vec = 10'd1023;
    logic [9:0]  top_pend_vec = 10'd1023;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_p = '0;
    logic [7:0] exp_a = '0;
    logic [2:0] exp_en = '0;

    always #2 clk = ~clk;

    sxs_status_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_set(hw_set),
        .ack_valid(ack_valid), .ack_id(ack_id), .done_valid(done_valid),
        .done_id(done_id), .run_vec(run_vec), .top_pend_vec(top_pend_vec)
    );

    function automatic logic [8:0] vmap(input int v);
        int r;
        if (v == 1023)   r = 0;
        else if (v >= 32) r = v - 16;
        else              r = v;
        return 9'(r);
    endfunction

    function automatic logic [31:0] exp_ctrl(input int rv, input int pv);
        logic [31:0] w = '0;
        w[8:0]   = vmap(rv);
        w[20:12] = vmap(pv);
        w[31] = exp_p[0];
        w[28] = exp_p[1];
        w[26] = exp_p[2];
        return w;
    endfunction

    function automatic logic [31:0] exp_hnd();
        logic [31:0] w = '0;
        w[0] = exp_a[3];  w[1] = exp_a[4];  w[3] = exp_a[5];
        w[7] = exp_a[6];  w[8] = exp_a[7];  w[10] = exp_a[1]; w[11] = exp_a[2];
        w[12] = exp_p[5]; w[13] = exp_p[3]; w[14] = exp_p[4]; w[15] = exp_p[6];
        w[18:16] = exp_en;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read both words between edges
    task automatic check_words(input string req);
        reg_sel = 1'b0; #0.4;
        chk(req, reg_rdata, exp_ctrl(1023, 1023));
        reg_sel = 1'b1; #0.4;
        chk(req, reg_rdata, exp_hnd());
        reg_sel = 1'b0;
    endtask

    // one clock of stimulus, launched after a falling edge
    task automatic cyc(input logic [7:0] hs, input logic av, input int ai,
                       input logic dv, input int di,
                       input logic w, input logic s, input logic [31:0] d);
        hw_set = hs; ack_valid = av; ack_id = 3'(ai);
        done_valid = dv; done_id = 3'(di);
        reg_wr = w; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        hw_set = '0; ack_valid = 1'b0; done_valid = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check_words("R13");

        // R5 running vector field sweep
        for (int v = 0; v < 528; v++) begin
            run_vec = 10'(v); #0.1;
            chk("R5", {23'd0, reg_rdata[8:0]}, {23'd0, vmap(v)});
        end
        run_vec = 10'd1023; #0.1;
        chk("R5 idle", reg_rdata, exp_ctrl(1023, 1023));

        // R6 pending vector field sweep
        for (int v = 0; v < 528; v++) begin
            top_pend_vec = 10'(v); #0.1;
            chk("R6", reg_rdata, exp_ctrl(1023, v));
        end
        top_pend_vec = 10'd1023; #0.1;
        chk("R6 idle", reg_rdata, exp_ctrl(1023, 1023));
        @(negedge clk);

        // R4 R7 R8 R10 R11: pend, acknowledge, complete each exception
        for (int i = 0; i < 8; i++) begin
            cyc(8'(1 << i), 0, 0, 0, 0, 0, 0, '0);
            exp_p[i] = 1'b1;
            check_words("R4/R8 pend");
            cyc('0, 1, i, 0, 0, 0, 0, '0);
            exp_p[i] = 1'b0; exp_a[i] = 1'b1;
            check_words("R7/R10 ack");
            cyc('0, 0, 0, 1, i, 0, 0, '0);
            exp_a[i] = 1'b0;
            check_words("R11 done");
        end

        // R10 acknowledge of a non-pending index
        cyc('0, 1, 5, 0, 0, 0, 0, '0);
        check_words("R10 no pend");

        // R1 software NMI pend
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h8000_0000);
        exp_p[0] = 1'b1;
        check_words("R1");
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0800_0000); // clear strobes leave NMI
        check_words("R1 no clear");

        // R2 pendable service
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h1000_0000);
        exp_p[1] = 1'b1;
        check_words("R2 set");
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0800_0000);
        exp_p[1] = 1'b0;
        check_words("R2 clear");
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h1800_0000);
        exp_p[1] = 1'b1;
        check_words("R2 set wins");

        // R3 tick
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0400_0000);
        exp_p[2] = 1'b1;
        check_words("R3 set");
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0200_0000);
        exp_p[2] = 1'b0;
        check_words("R3 clear");
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0600_0000);
        exp_p[2] = 1'b1;
        check_words("R3 set wins");

        // R12 hardware set against software clear
        cyc('0, 0, 0, 0, 0, 1, 0, 32'h0200_0000);
        exp_p[2] = 1'b0;
        cyc(8'h04, 0, 0, 0, 0, 1, 0, 32'h0200_0000);
        exp_p[2] = 1'b1;
        check_words("R12");

        // R9 handler writes touch only enables
        cyc(8'h78, 0, 0, 0, 0, 0, 0, '0);
        exp_p[6:3] = 4'hF;
        cyc('0, 1, 6, 0, 0, 0, 0, '0);
        exp_p[6] = 1'b0; exp_a[6] = 1'b1;
        cyc('0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
        exp_en = 3'b111;
        check_words("R9 all ones");
        cyc('0, 0, 0, 0, 0, 1, 1, 32'h0002_0000);
        exp_en = 3'b010;
        check_words("R9 partial");
        cyc('0, 0, 0, 0, 0, 1, 1, 32'h0000_FFFF);
        exp_en = 3'b000;
        check_words("R9 clear");

        // R10 acknowledge with a new set in the same cycle
        cyc(8'h08, 1, 3, 0, 0, 0, 0, '0);
        exp_p[3] = 1'b1; exp_a[3] = 1'b1;
        check_words("R10 ack+set");

        // R11 acknowledge and completion together
        cyc('0, 1, 4, 1, 4, 0, 0, '0);
        exp_p[4] = 1'b0; exp_a[4] = 1'b1;
        check_words("R11 ack wins");
        cyc('0, 0, 0, 1, 4, 0, 0, '0);
        exp_a[4] = 1'b0;
        check_words("R11 done");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule